// File: doc/BRIEF.md
# Stereo Audio Frame Buffer with Rate Pacer

This block sits between a byte-wide reader that streams raw audio out of storage and a stereo DAC. The incoming stream is 16-bit stereo with the most significant byte of each sample first and the left channel ahead of the right. The block turns every four accepted bytes into one stereo frame and stores the frame in a FIFO.

A phase accumulator produces one frame strobe for each period of the output sample rate. The divider is fractional because the system clock is not a whole multiple of the sample rate. On each strobe the oldest frame leaves the FIFO and is held on the sample outputs. If the FIFO is empty at that moment, silence goes out instead and the strobe keeps its rate.

For the upstream reader, the block drives a hysteretic data-request flag, an 8-bit fill gauge and a loaded flag. The loaded flag shows that playback has built up a working reserve of frames.

Top module: `audio_frame_pacer`

## Requirements
- R1: While reset is asserted and in the cycle after it is released: fill_level is 0x00, fifo_loaded is 0, data_req is 1, in_ready is 1, sample_strobe is 0, and both sample outputs are 0.
- R2: A byte is taken on a clock edge where in_valid and in_ready are both 1. Taken bytes fill the frame slots in this order: left high, left low, right high, right low. Each sample is {high byte, low byte}.
- R3: Frames leave the FIFO in the order they were completed, one frame per strobe.
- R4: The internal pacer adds RATE_HZ to an accumulator every cycle, modulo CLK_HZ, and raises a tick on each wrap. sample_strobe is high for exactly one cycle, in the cycle after each tick. Over any window of CLK_HZ cycles there are exactly RATE_HZ strobes, and each gap between strobes is the floor or the ceiling of CLK_HZ/RATE_HZ.
- R5: A strobe that finds the FIFO empty outputs 0 on both channels, and the strobe rate is unchanged.
- R6: fill_level equals occupancy*256/DEPTH, saturated to 0xFF. It tracks occupancy in the same cycle, with DEPTH = 2^DEPTH_LOG2 frames.
- R7: in_ready is 0 exactly when the FIFO holds DEPTH frames. Bytes offered while it is 0 are not taken, and the FIFO contents and fill level stay the same.
- R8: data_req is registered. It becomes 1 when occupancy is below DEPTH/2 and 0 when occupancy is at or above 3*DEPTH/4. Between those levels it keeps its previous value.
- R9: fifo_loaded is registered. It becomes 1 when occupancy reaches DEPTH/2 or more, and 0 when occupancy is zero. Otherwise it holds.
- R10: Reset returns the byte slot to left-high and discards any partly assembled frame. The first frame after reset therefore keeps its alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Upstream byte valid |
| in_ready | output | 1 | Block can take a byte |
| in_data | input | 8 | Upstream byte |
| sample_strobe | output | 1 | One-cycle frame strobe |
| sample_left | output | 16 | Left sample, held between strobes |
| sample_right | output | 16 | Right sample, held between strobes |
| data_req | output | 1 | Request for more bytes (hysteretic) |
| fill_level | output | 8 | FIFO fill gauge, 0x00 empty to 0xFF full |
| fifo_loaded | output | 1 | Reserve built up since the last empty |

## Verification
The hard cases are the hysteresis band and the full-FIFO stall. To reach them, the FIFO must be filled and drained one frame at a time with no frame leaving in between. The bench uses a small FIFO of eight frames and a slow pacer of three strobes per thousand cycles. This lets it fill the FIFO completely and offer bytes while it is full, all before the first strobe. It then checks gauge, request and loaded at every occupancy step on the way up and on the way down. The drain continues into underrun. A reset placed in the middle of a frame then checks byte alignment.

// File: rtl/afp_pkg.sv
package afp_pkg;

  localparam int BYTE_W   = 8;
  localparam int SAMPLE_W = 16;

  typedef struct packed {
    logic [SAMPLE_W-1:0] left;
    logic [SAMPLE_W-1:0] right;
  } frame_t;

  // Byte slot within a frame; the order is the arrival order.
  typedef enum logic [1:0] {
    SLOT_LH = 2'd0,
    SLOT_LL = 2'd1,
    SLOT_RH = 2'd2,
    SLOT_RL = 2'd3
  } byte_slot_e;

  // Occupancy scaled to an 8-bit gauge, saturating at 0xFF when full.
  function automatic logic [7:0] fill_gauge(input logic [31:0] occ,
                                            input int depth_log2);
    logic [39:0] scaled;
    scaled = ({8'd0, occ} << 8) >> depth_log2;
    if (scaled > 40'd255) return 8'hFF;
    return scaled[7:0];
  endfunction

  // Hysteretic request: set below half, clear at three quarters.
  function automatic logic request_next(input logic cur,
                                        input logic [31:0] occ,
                                        input int depth_log2);
    logic [31:0] depth;
    depth = 32'd1 << depth_log2;
    if (occ < (depth >> 1)) return 1'b1;
    if (occ >= (depth >> 1) + (depth >> 2)) return 1'b0;
    return cur;
  endfunction

  // Loaded flag: set at half, clear only when empty.
  function automatic logic loaded_next(input logic cur,
                                       input logic [31:0] occ,
                                       input int depth_log2);
    logic [31:0] depth;
    depth = 32'd1 << depth_log2;
    if (occ == 32'd0) return 1'b0;
    if (occ >= (depth >> 1)) return 1'b1;
    return cur;
  endfunction

endpackage

// File: rtl/afp_byte_assembler.sv
module afp_byte_assembler
  import afp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_take_en,
  input  logic [BYTE_W-1:0] in_data,
  output logic              frame_done,
  output frame_t            frame_out
);

  byte_slot_e        slot_q;
  logic [BYTE_W-1:0] lh_q, ll_q, rh_q;
  logic              byte_take;

  assign byte_take = in_valid & in_take_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= SLOT_LH;
      lh_q   <= '0;
      ll_q   <= '0;
      rh_q   <= '0;
    end else if (byte_take) begin
      case (slot_q)
        SLOT_LH: lh_q <= in_data;
        SLOT_LL: ll_q <= in_data;
        SLOT_RH: rh_q <= in_data;
        default: ;
      endcase
      slot_q <= byte_slot_e'(slot_q + 2'd1);
    end
  end

  assign frame_done = byte_take && (slot_q == SLOT_RL);
  assign frame_out  = {lh_q, ll_q, rh_q, in_data};

endmodule

// File: rtl/afp_frame_fifo.sv
module afp_frame_fifo
  import afp_pkg::*;
#(
  parameter int DEPTH_LOG2 = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                push,
  input  frame_t              push_frame,
  input  logic                pop,
  output frame_t              head_frame,
  output logic                empty,
  output logic                full,
  output logic [DEPTH_LOG2:0] occupancy
);

  localparam int DEPTH = 1 << DEPTH_LOG2;

  frame_t                mem [DEPTH];
  logic [DEPTH_LOG2-1:0] wr_q, rd_q;
  logic [DEPTH_LOG2:0]   occ_q;
  logic                  do_push, do_pop;

  assign empty   = (occ_q == '0);
  assign full    = (occ_q == (DEPTH_LOG2+1)'(DEPTH));
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= push_frame;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q  <= '0;
      rd_q  <= '0;
      occ_q <= '0;
    end else begin
      if (do_push) wr_q <= wr_q + 1'b1;
      if (do_pop)  rd_q <= rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   occ_q <= occ_q + 1'b1;
        2'b01:   occ_q <= occ_q - 1'b1;
        default: ;
      endcase
    end
  end

  assign head_frame = mem[rd_q];
  assign occupancy  = occ_q;

endmodule

// File: rtl/afp_rate_pacer.sv
module afp_rate_pacer #(
  parameter int CLK_HZ  = 100_000_000,
  parameter int RATE_HZ = 44_100
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);

  localparam int ACC_W = $clog2(CLK_HZ + RATE_HZ) + 1;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] sum;

  assign sum  = acc_q + ACC_W'(RATE_HZ);
  assign tick = (sum >= ACC_W'(CLK_HZ));

  always_ff @(posedge clk) begin
    if (rst)       acc_q <= '0;
    else if (tick) acc_q <= sum - ACC_W'(CLK_HZ);
    else           acc_q <= sum;
  end

endmodule

// File: rtl/audio_frame_pacer.sv
module audio_frame_pacer
  import afp_pkg::*;
#(
  parameter int DEPTH_LOG2 = 8,
  parameter int CLK_HZ     = 100_000_000,
  parameter int RATE_HZ    = 44_100
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [BYTE_W-1:0]   in_data,
  output logic                sample_strobe,
  output logic [SAMPLE_W-1:0] sample_left,
  output logic [SAMPLE_W-1:0] sample_right,
  output logic                data_req,
  output logic [7:0]          fill_level,
  output logic                fifo_loaded
);

  logic                frame_done;
  frame_t              asm_frame;
  frame_t              head_frame;
  logic                fifo_empty;
  logic                fifo_full;
  logic [DEPTH_LOG2:0] occupancy;
  logic                pace_tick;
  logic                frame_pop;

  afp_byte_assembler u_asm (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_take_en (in_ready),
    .in_data    (in_data),
    .frame_done (frame_done),
    .frame_out  (asm_frame)
  );

  afp_frame_fifo #(.DEPTH_LOG2(DEPTH_LOG2)) u_fifo (
    .clk        (clk),
    .rst        (rst),
    .push       (frame_done),
    .push_frame (asm_frame),
    .pop        (frame_pop),
    .head_frame (head_frame),
    .empty      (fifo_empty),
    .full       (fifo_full),
    .occupancy  (occupancy)
  );

  afp_rate_pacer #(.CLK_HZ(CLK_HZ), .RATE_HZ(RATE_HZ)) u_pace (
    .clk  (clk),
    .rst  (rst),
    .tick (pace_tick)
  );

  assign in_ready   = ~fifo_full;
  assign frame_pop  = pace_tick & ~fifo_empty;
  assign fill_level = fill_gauge(32'(occupancy), DEPTH_LOG2);

  always_ff @(posedge clk) begin
    if (rst) begin
      sample_strobe <= 1'b0;
      sample_left   <= '0;
      sample_right  <= '0;
      data_req      <= 1'b1;
      fifo_loaded   <= 1'b0;
    end else begin
      sample_strobe <= pace_tick;
      if (pace_tick) begin
        sample_left  <= fifo_empty ? '0 : head_frame.left;
        sample_right <= fifo_empty ? '0 : head_frame.right;
      end
      data_req    <= request_next(data_req, 32'(occupancy), DEPTH_LOG2);
      fifo_loaded <= loaded_next(fifo_loaded, 32'(occupancy), DEPTH_LOG2);
    end
  end

endmodule

// File: rtl/afp_checker.sv
module afp_checker #(
  parameter int DEPTH_LOG2 = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                in_ready,
  input logic                sample_strobe,
  input logic [15:0]         sample_left,
  input logic [15:0]         sample_right,
  input logic                data_req,
  input logic [7:0]          fill_level,
  input logic                fifo_loaded,
  input logic                fifo_empty,
  input logic                pace_tick,
  input logic [DEPTH_LOG2:0] occupancy
);

  localparam int DEPTH = 1 << DEPTH_LOG2;

  // R4
  strobe_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
    pace_tick |=> sample_strobe);

  // R4
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    sample_strobe |=> !sample_strobe);

  // R5
  underrun_silence_chk: assert property (@(posedge clk) disable iff (rst)
    (sample_strobe && $past(fifo_empty)) |-> (sample_left == 16'd0 && sample_right == 16'd0));

  // R7
  full_gauge_chk: assert property (@(posedge clk) disable iff (rst)
    !in_ready |-> (fill_level == 8'hFF));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    occupancy <= (DEPTH_LOG2+1)'(DEPTH));

  // R8
  req_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(data_req) |-> ($past(fill_level) >= 8'd192));

  // R8
  req_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(data_req) |-> ($past(fill_level) < 8'd128));

  // R9
  loaded_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (fill_level == 8'd0) |=> !fifo_loaded);

endmodule

bind audio_frame_pacer afp_checker #(.DEPTH_LOG2(DEPTH_LOG2)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .in_ready      (in_ready),
  .sample_strobe (sample_strobe),
  .sample_left   (sample_left),
  .sample_right  (sample_right),
  .data_req      (data_req),
  .fill_level    (fill_level),
  .fifo_loaded   (fifo_loaded),
  .fifo_empty    (fifo_empty),
  .pace_tick     (pace_tick),
  .occupancy     (occupancy)
);

// File: tb/sim_audio_frame_pacer.sv
`timescale 1ns/1ps
module sim_audio_frame_pacer;

  localparam int DL2   = 3;
  localparam int DEPTH = 1 << DL2;
  localparam int CLKHZ = 1000;
  localparam int RATE  = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'd0;
  logic        in_ready, sample_strobe, data_req, fifo_loaded;
  logic [15:0] sample_left, sample_right;
  logic [7:0]  fill_level;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  int occ_m = 0;
  bit req_m = 1;
  bit ld_m = 0;
  int last_strobe = -1;
  logic [15:0] exp_l [DEPTH];
  logic [15:0] exp_r [DEPTH];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  audio_frame_pacer #(.DEPTH_LOG2(DL2), .CLK_HZ(CLKHZ), .RATE_HZ(RATE)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .sample_strobe(sample_strobe), .sample_left(sample_left),
    .sample_right(sample_right), .data_req(data_req), .fill_level(fill_level),
    .fifo_loaded(fifo_loaded)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] gauge_m(input int occ);
    int g;
    g = (occ * 256) / DEPTH;
    return (g > 255) ? 8'hFF : g[7:0];
  endfunction

  task automatic model_step();
    if (occ_m < DEPTH / 2) req_m = 1;
    else if (occ_m * 4 >= DEPTH * 3) req_m = 0;
    if (occ_m == 0) ld_m = 0;
    else if (occ_m * 2 >= DEPTH) ld_m = 1;
  endtask

  task automatic check_status(input string where);
    chk(fill_level == gauge_m(occ_m), {"R6 gauge ", where}, fill_level, gauge_m(occ_m));
    chk(data_req == req_m, {"R8 request ", where}, data_req, req_m);
    chk(fifo_loaded == ld_m, {"R9 loaded ", where}, fifo_loaded, ld_m);
    chk(in_ready == (occ_m < DEPTH), {"R7 ready ", where}, in_ready, occ_m < DEPTH);
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic send_frame(input logic [15:0] l, input logic [15:0] r, input bit gap);
    send_byte(l[15:8]);
    if (gap) begin @(negedge clk); in_valid = 1'b0; end
    send_byte(l[7:0]);
    send_byte(r[15:8]);
    if (gap) begin @(negedge clk); in_valid = 1'b0; end
    send_byte(r[7:0]);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_strobe();
    do @(negedge clk); while (!sample_strobe);
    if (last_strobe >= 0)
      chk((cyc - last_strobe == CLKHZ / RATE) || (cyc - last_strobe == CLKHZ / RATE + 1),
          "R4 strobe gap", cyc - last_strobe, CLKHZ / RATE);
    last_strobe = cyc;
  endtask

  task automatic check_reset_state();
    chk(fill_level == 8'd0, "R1 fill", fill_level, 0);
    chk(fifo_loaded == 1'b0, "R1 loaded", fifo_loaded, 0);
    chk(data_req == 1'b1, "R1 request", data_req, 1);
    chk(in_ready == 1'b1, "R1 ready", in_ready, 1);
    chk(sample_strobe == 1'b0, "R1 strobe", sample_strobe, 0);
    chk(sample_left == 16'd0 && sample_right == 16'd0, "R1 samples",
        {sample_left, sample_right}, 0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R4 watchdog expired actual=%0d expected=done", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_reset_state();
    rst = 1'b0;
    @(negedge clk);
    check_reset_state();

    // Fill before the first strobe (R2, R6, R8, R9 at every level)
    for (int i = 0; i < DEPTH; i++) begin
      exp_l[i] = 16'hA000 + 16'(i * 16'h0111);
      exp_r[i] = 16'h5A00 ^ 16'(i * 16'h1203);
      send_frame(exp_l[i], exp_r[i], i[0]);
      occ_m++;
      @(negedge clk);
      model_step();
      check_status("fill");
    end

    // R7: bytes offered while full are not taken
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 8'hEE;
    repeat (6) @(negedge clk);
    chk(in_ready == 1'b0, "R7 ready low when full", in_ready, 0);
    in_valid = 1'b0;
    @(negedge clk);
    chk(fill_level == 8'hFF, "R7 fill unchanged", fill_level, 8'hFF);

    // Drain: order (R3), content (R2), gaps (R4), status on the way down
    for (int i = 0; i < DEPTH; i++) begin
      wait_strobe();
      chk(sample_left == exp_l[i], "R3 left order", sample_left, exp_l[i]);
      chk(sample_right == exp_r[i], "R2 right bytes", sample_right, exp_r[i]);
      occ_m--;
      @(negedge clk);
      model_step();
      check_status("drain");
      chk(sample_strobe == 1'b0, "R4 single cycle", sample_strobe, 0);
    end

    // R5: underrun keeps strobing with silence
    for (int k = 0; k < 3; k++) begin
      wait_strobe();
      chk(sample_left == 16'd0 && sample_right == 16'd0, "R5 silence",
          {sample_left, sample_right}, 0);
    end

    // R10: reset in the middle of a frame
    send_byte(8'hAA);
    send_byte(8'hBB);
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check_reset_state();
    rst = 1'b0;
    last_strobe = -1;
    occ_m = 0; req_m = 1; ld_m = 0;
    send_frame(16'h1234, 16'h5678, 1'b0);
    wait_strobe();
    chk(sample_left == 16'h1234, "R10 left aligned", sample_left, 16'h1234);
    chk(sample_right == 16'h5678, "R10 right aligned", sample_right, 16'h5678);

    // R4: exact strobe count over a window of CLKHZ*3 cycles
    begin
      int cnt;
      cnt = 0;
      for (int c = 0; c < CLKHZ * 3; c++) begin
        @(negedge clk);
        if (sample_strobe) cnt++;
      end
      chk(cnt == RATE * 3, "R4 strobe count", cnt, RATE * 3);
    end

    done = 1;
    finish_run();
  end

endmodule